// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block stands in for the read side of a parallel flash part while its internal program or erase algorithm runs. A command decoder elsewhere hands it one-cycle events: start a program (address and data byte), start an erase (a mask of selected sectors), suspend or resume an erase, and an algorithm-finished pulse from the array model. The block keeps the operation state, answers host reads with either a polling status byte or the array word supplied by the caller, and drives an active-low busy line.

Reads are combinational on `rd_addr`. Only an address that is a polling target gets status. During a program the target is the program address. During an erase or a suspend the target is any address in a selected sector that is being erased. Every other address returns `array_data`. Status begins on the cycle after the clock edge that captures a command. A program into a protected sector, or an erase whose selected sectors are all protected, holds status for a fixed number of clock cycles, then returns to array reads without touching the array. The hold is 1 µs for a program and 100 µs for an erase, both counted from a clock-frequency parameter.

The controller has eight states. `ST_READ` is idle array reading. `ST_PROG` and `ST_PROG_ABORT` run a normal program and a protected program. `ST_ERASE` and `ST_ERASE_ABORT` run a normal erase and an all-protected erase. `ST_SUSP` is a suspended erase. `ST_SPROG` and `ST_SPROG_ABORT` are programs issued while the erase is suspended. The transitions are:
- `ST_READ` to `ST_PROG` or `ST_PROG_ABORT` on a program command.
- `ST_READ` to `ST_ERASE` or `ST_ERASE_ABORT` on an erase command.
- `ST_PROG` to `ST_READ` on the done pulse.
- `ST_ERASE` to `ST_READ` on the done pulse.
- `ST_ERASE` to `ST_SUSP` on a suspend.
- `ST_SUSP` to `ST_ERASE` on a resume.
- `ST_SUSP` to `ST_SPROG` or `ST_SPROG_ABORT` on a program command.
- `ST_SPROG` to `ST_SUSP` on the done pulse.
- Each abort state to its origin (`ST_READ` or `ST_SUSP`) when the timer expires.

Top module: `flash_status_resp`

## Requirements
- R1: The polling status byte is laid out as follows. During a program, a read at the program address returns bit 7 equal to the complement of bit 7 of the data being programmed. Bits 6..0 return the parameter `STAT_FILL`. This starts on the cycle after the capturing edge.
- R2: The done pulse ends a program. From the next cycle `busy_n` is 1 and reads at the program address return `array_data`.
- R3: During an erase, a read in a sector being erased returns bit 7 = 0. The sector index is `rd_addr[15:13]`, and mask bit i selects sector i. The done pulse ends the erase: `busy_n` rises and reads return `array_data`.
- R4: Addresses outside the polling target return `array_data`. For a program this is any other address. For an erase it is any unselected sector.
- R5: A program into a protected sector keeps `busy_n` low for exactly CLK_MHZ×PROG_TMO_US cycles, which is 50 by default. Reads at the target show the complemented bit 7 during that time. The done pulse is ignored. Afterwards reads return `array_data`.
- R6: An erase whose selected sectors are all protected keeps `busy_n` low for exactly CLK_MHZ×ERASE_TMO_US cycles, which is 5000 by default. Bit 7 reads 0 in those sectors. Afterwards reads return `array_data`.
- R7: When only some selected sectors are protected, the erase runs. Protected selected sectors return `array_data`. Unprotected selected sectors poll 0.
- R8: A suspend during an erase releases `busy_n`, and reads in an erased sector return bit 7 = 1. A resume returns to bit 7 = 0 with `busy_n` low.
- R9: A program during suspend polls with the complemented bit 7 and drives `busy_n` low. Its done pulse returns to the suspended state, with `busy_n` high and bit 7 = 1 in erased sectors.
- R10: An erase command issued while a program runs is ignored. `busy_n` stays low and the program status is kept.
- R11: After reset `busy_n` is 1 and reads return `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_prog | input | 1 | Program start event (one cycle) |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_data | input | 8 | Byte being programmed |
| cmd_erase | input | 1 | Erase start event (one cycle) |
| erase_sel | input | 2**SECT_W | Sectors selected for erase |
| cmd_suspend | input | 1 | Erase suspend event |
| cmd_resume | input | 1 | Erase resume event |
| op_done | input | 1 | Internal algorithm finished |
| sect_prot | input | 2**SECT_W | Per-sector protection flags |
| rd_addr | input | ADDR_W | Host read address |
| array_data | input | 8 | Array word for the read address |
| rd_data | output | 8 | Read result |
| busy_n | output | 1 | Active-low busy, open-drain style |

## Verification
The properties assume that command events are single-cycle pulses and that `op_done` arrives only while a real algorithm runs. They also assume that `sect_prot` does not change while an operation is in flight. The bench drives each event for exactly one cycle between falling edges. It sets protection before issuing a command and keeps it constant until the operation ends. It issues `op_done` only in the states that expect it, except for the deliberate ignore case of R5. Reads change only `rd_addr`, and the result is sampled a moment later, away from any clock edge.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_PROG_ABORT,
        ST_ERASE,
        ST_ERASE_ABORT,
        ST_SUSP,
        ST_SPROG,
        ST_SPROG_ABORT
    } fsr_state_e;

endpackage

// File: rtl/fsr_sector_dec.sv
module fsr_sector_dec #(
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic [SECT_W-1:0] sect_idx,
    output logic [NSECT-1:0]  sect_oh
);

    for (genvar gi = 0; gi < NSECT; gi++) begin : g_dec
        assign sect_oh[gi] = (sect_idx == SECT_W'(gi));
    end

endmodule

// File: rtl/fsr_abort_timer.sv
module fsr_abort_timer #(
    parameter int SHORT_CYC = 50,
    parameter int LONG_CYC  = 5000,
    localparam int MAX_CYC  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
    localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic use_long,
    output logic expired
);

    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= use_long ? LONG_LD : SHORT_LD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/fsr_read_mux.sv
module fsr_read_mux #(
    parameter int         ADDR_W    = 16,
    parameter int         SECT_W    = 3,
    parameter logic [6:0] STAT_FILL = 7'h00,
    localparam int        NSECT     = 1 << SECT_W
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NSECT-1:0]  rd_oh,
    input  logic [7:0]        array_data,
    input  logic              poll_prog,
    input  logic              poll_erase,
    input  logic              poll_susp,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              prog_b7,
    input  logic [NSECT-1:0]  erase_mask,
    output logic [7:0]        rd_data
);

    logic hit_prog;
    logic hit_erase;

    assign hit_prog  = poll_prog && (rd_addr == prog_addr);
    assign hit_erase = |(rd_oh & erase_mask);

    always_comb begin
        if (hit_prog) begin
            rd_data = {~prog_b7, STAT_FILL};
        end else if (hit_erase && poll_erase) begin
            rd_data = {1'b0, STAT_FILL};
        end else if (hit_erase && poll_susp) begin
            rd_data = {1'b1, STAT_FILL};
        end else begin
            rd_data = array_data;
        end
    end

endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
    import flash_status_pkg::*;
#(
    parameter int         ADDR_W       = 16,
    parameter int         SECT_W       = 3,
    parameter int         CLK_MHZ      = 50,
    parameter int         PROG_TMO_US  = 1,
    parameter int         ERASE_TMO_US = 100,
    parameter logic [6:0] STAT_FILL    = 7'h00,
    localparam int        NSECT        = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_prog,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              cmd_erase,
    input  logic [NSECT-1:0]  erase_sel,
    input  logic              cmd_suspend,
    input  logic              cmd_resume,
    input  logic              op_done,
    input  logic [NSECT-1:0]  sect_prot,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        array_data,
    output logic [7:0]        rd_data,
    output logic              busy_n
);

    localparam int PROG_CYC  = CLK_MHZ * PROG_TMO_US;
    localparam int ERASE_CYC = CLK_MHZ * ERASE_TMO_US;

    fsr_state_e        state_q, state_d;
    logic [ADDR_W-1:0] prog_addr_q;
    logic              prog_b7_q;
    logic [NSECT-1:0]  erase_mask_q;
    logic [NSECT-1:0]  cmd_oh, rd_oh;
    logic              prog_go, prog_prot, erase_go, erase_all_prot;
    logic              tmo_load, tmo_expired;
    logic              poll_prog, poll_erase, poll_susp;

    fsr_sector_dec #(.SECT_W(SECT_W)) u_cmd_dec (
        .sect_idx (cmd_addr[ADDR_W-1 -: SECT_W]),
        .sect_oh  (cmd_oh)
    );

    fsr_sector_dec #(.SECT_W(SECT_W)) u_rd_dec (
        .sect_idx (rd_addr[ADDR_W-1 -: SECT_W]),
        .sect_oh  (rd_oh)
    );

    assign prog_go        = cmd_prog && (state_q == ST_READ || state_q == ST_SUSP);
    assign prog_prot      = |(cmd_oh & sect_prot);
    assign erase_go       = cmd_erase && !cmd_prog && (state_q == ST_READ) && (|erase_sel);
    assign erase_all_prot = ((erase_sel & ~sect_prot) == '0);
    assign tmo_load       = (prog_go && prog_prot) || (erase_go && erase_all_prot);

    fsr_abort_timer #(.SHORT_CYC(PROG_CYC), .LONG_CYC(ERASE_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmo_load),
        .use_long (!prog_go),
        .expired  (tmo_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ;
        end else begin
            state_q <= state_d;
        end
    end

    // captured operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_addr_q  <= '0;
            prog_b7_q    <= 1'b0;
            erase_mask_q <= '0;
        end else begin
            if (prog_go) begin
                prog_addr_q <= cmd_addr;
                prog_b7_q   <= cmd_data[7];
            end
            if (erase_go) begin
                erase_mask_q <= erase_all_prot ? erase_sel : (erase_sel & ~sect_prot);
            end
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ: begin
                if (prog_go) begin
                    state_d = prog_prot ? ST_PROG_ABORT : ST_PROG;
                end else if (erase_go) begin
                    state_d = erase_all_prot ? ST_ERASE_ABORT : ST_ERASE;
                end
            end
            ST_PROG:        if (op_done) state_d = ST_READ;
            ST_PROG_ABORT:  if (tmo_expired) state_d = ST_READ;
            ST_ERASE: begin
                if (op_done) begin
                    state_d = ST_READ;
                end else if (cmd_suspend) begin
                    state_d = ST_SUSP;
                end
            end
            ST_ERASE_ABORT: if (tmo_expired) state_d = ST_READ;
            ST_SUSP: begin
                if (prog_go) begin
                    state_d = prog_prot ? ST_SPROG_ABORT : ST_SPROG;
                end else if (cmd_resume) begin
                    state_d = ST_ERASE;
                end
            end
            ST_SPROG:       if (op_done) state_d = ST_SUSP;
            ST_SPROG_ABORT: if (tmo_expired) state_d = ST_SUSP;
            default:        state_d = ST_READ;
        endcase
    end

    // outputs
    always_comb begin
        busy_n     = 1'b0;
        poll_prog  = 1'b0;
        poll_erase = 1'b0;
        poll_susp  = 1'b0;
        unique case (state_q)
            ST_READ:        busy_n = 1'b1;
            ST_PROG,
            ST_PROG_ABORT:  poll_prog = 1'b1;
            ST_ERASE,
            ST_ERASE_ABORT: poll_erase = 1'b1;
            ST_SUSP: begin
                busy_n    = 1'b1;
                poll_susp = 1'b1;
            end
            ST_SPROG,
            ST_SPROG_ABORT: begin
                poll_prog = 1'b1;
                poll_susp = 1'b1;
            end
            default:        busy_n = 1'b1;
        endcase
    end

    fsr_read_mux #(
        .ADDR_W    (ADDR_W),
        .SECT_W    (SECT_W),
        .STAT_FILL (STAT_FILL)
    ) u_rd_mux (
        .rd_addr    (rd_addr),
        .rd_oh      (rd_oh),
        .array_data (array_data),
        .poll_prog  (poll_prog),
        .poll_erase (poll_erase),
        .poll_susp  (poll_susp),
        .prog_addr  (prog_addr_q),
        .prog_b7    (prog_b7_q),
        .erase_mask (erase_mask_q),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import flash_status_pkg::*;
#(
    parameter int  ADDR_W = 16,
    parameter int  SECT_W = 3,
    localparam int NSECT  = 1 << SECT_W
) (
    input logic              clk,
    input logic              rst_n,
    input fsr_state_e        state_q,
    input logic [ADDR_W-1:0] prog_addr_q,
    input logic              prog_b7_q,
    input logic [NSECT-1:0]  erase_mask_q,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              busy_n,
    input logic              op_done,
    input logic              cmd_erase,
    input logic              tmo_expired
);

    logic rd_in_erase;
    assign rd_in_erase = erase_mask_q[rd_addr[ADDR_W-1 -: SECT_W]];

    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && rd_addr == prog_addr_q) |-> (rd_data[7] != prog_b7_q)); // R1

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && op_done) |=> busy_n); // R2

    AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE && rd_in_erase) |-> !rd_data[7]); // R3

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG_ABORT && !tmo_expired) |=> (state_q == ST_PROG_ABORT && !busy_n)); // R5

    AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP) |-> (busy_n && (!rd_in_erase || rd_data[7]))); // R8

    AST_ERASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && cmd_erase && !op_done) |=> (state_q == ST_PROG)); // R10

endmodule

bind flash_status_resp fsr_checker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .prog_addr_q  (prog_addr_q),
    .prog_b7_q    (prog_b7_q),
    .erase_mask_q (erase_mask_q),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .busy_n       (busy_n),
    .op_done      (op_done),
    .cmd_erase    (cmd_erase),
    .tmo_expired  (tmo_expired)
);

// File: tb/flash_status_resp_tb.sv
module flash_status_resp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_prog = 1'b0, cmd_erase = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0, op_done = 1'b0;
    logic [15:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0]  cmd_data = '0, erase_sel = '0, sect_prot = '0, array_data = 8'h5A;
    logic [7:0]  rd_data;
    logic        busy_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_status_resp u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_prog(cmd_prog), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_erase(cmd_erase), .erase_sel(erase_sel),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .op_done(op_done),
        .sect_prot(sect_prot), .rd_addr(rd_addr), .array_data(array_data),
        .rd_data(rd_data), .busy_n(busy_n)
    );

    // {address, data}
    localparam logic [23:0] PROG_VEC [6] = '{
        24'h0010_80, 24'h2345_00, 24'h4FFF_FF, 24'h6001_7F, 24'hA0C3_C3, 24'hFFFE_3C
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_n === 1'b0 && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        // R11: reset state
        rd(16'h0010, v);
        chk("R11 busy after reset", {7'd0, busy_n}, 8'h01);
        chk("R11 array read after reset", v, 8'h5A);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R4: table of program vectors
        foreach (PROG_VEC[i]) begin
            array_data = 8'hA5;
            cmd_addr = PROG_VEC[i][23:8];
            cmd_data = PROG_VEC[i][7:0];
            pulse(cmd_prog);
            rd(PROG_VEC[i][23:8], v);
            chk("R1 program poll bit7", {7'd0, v[7]}, {7'd0, ~PROG_VEC[i][7]});
            chk("R1 busy low", {7'd0, busy_n}, 8'h00);
            rd(PROG_VEC[i][23:8] ^ 16'h0001, v);
            chk("R4 other address array", v, 8'hA5);
            pulse(op_done);
            array_data = PROG_VEC[i][7:0];
            rd(PROG_VEC[i][23:8], v);
            chk("R2 array after done", v, PROG_VEC[i][7:0]);
            chk("R2 busy released", {7'd0, busy_n}, 8'h01);
        end

        // R10: erase during program ignored
        array_data = 8'h11;
        cmd_addr = 16'h4000; cmd_data = 8'h01;
        pulse(cmd_prog);
        erase_sel = 8'h01;
        pulse(cmd_erase);
        rd(16'h4000, v);
        chk("R10 program status kept", {7'd0, v[7]}, 8'h01);
        rd(16'h0000, v);
        chk("R10 no erase status", v, 8'h11);
        chk("R10 busy low", {7'd0, busy_n}, 8'h00);
        pulse(op_done);

        // R3, R4: plain erase of sectors 2 and 5
        erase_sel = 8'b0010_0100;
        pulse(cmd_erase);
        rd(16'h4123, v);
        chk("R3 erase poll zero", {7'd0, v[7]}, 8'h00);
        rd(16'hA000, v);
        chk("R3 erase poll zero sector5", {7'd0, v[7]}, 8'h00);
        rd(16'h2000, v);
        chk("R4 unselected sector array", v, 8'h11);
        chk("R3 busy low", {7'd0, busy_n}, 8'h00);
        pulse(op_done);
        rd(16'h4123, v);
        chk("R3 array after done", v, 8'h11);
        chk("R3 busy released", {7'd0, busy_n}, 8'h01);

        // R5: protected program
        sect_prot = 8'h80;
        array_data = 8'h22;
        cmd_addr = 16'hE000; cmd_data = 8'h80;
        pulse(cmd_prog);
        rd(16'hE000, v);
        chk("R5 protected poll bit7", {7'd0, v[7]}, 8'h00);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        count_busy(n);
        chk("R5 busy window", 8'(n + 1), 8'd50);
        rd(16'hE000, v);
        chk("R5 array after abort", v, 8'h22);

        // R6: all selected sectors protected
        sect_prot = 8'b0000_0110;
        erase_sel = 8'b0000_0110;
        pulse(cmd_erase);
        rd(16'h2000, v);
        chk("R6 all-protected poll", {7'd0, v[7]}, 8'h00);
        count_busy(n);
        checks++;
        if (n != 5000) begin
            errors++;
            $display("FAIL R6 busy window actual=%0d expected=%0d", n, 5000);
        end
        rd(16'h2000, v);
        chk("R6 array after abort", v, 8'h22);

        // R7: partial protection
        sect_prot = 8'b0000_0010;
        erase_sel = 8'b0000_0011;
        pulse(cmd_erase);
        rd(16'h0100, v);
        chk("R7 unprotected sector polls", {7'd0, v[7]}, 8'h00);
        rd(16'h2100, v);
        chk("R7 protected sector array", v, 8'h22);

        // R8: suspend and resume
        pulse(cmd_suspend);
        rd(16'h0100, v);
        chk("R8 suspend bit7", {7'd0, v[7]}, 8'h01);
        chk("R8 suspend busy released", {7'd0, busy_n}, 8'h01);

        // R9: program during suspend
        cmd_addr = 16'h8004; cmd_data = 8'h7E;
        pulse(cmd_prog);
        rd(16'h8004, v);
        chk("R9 suspend program poll", {7'd0, v[7]}, 8'h01);
        chk("R9 busy low", {7'd0, busy_n}, 8'h00);
        pulse(op_done);
        rd(16'h0100, v);
        chk("R9 back to suspend bit7", {7'd0, v[7]}, 8'h01);
        chk("R9 busy released", {7'd0, busy_n}, 8'h01);

        pulse(cmd_resume);
        rd(16'h0100, v);
        chk("R8 resume bit7", {7'd0, v[7]}, 8'h00);
        chk("R8 resume busy", {7'd0, busy_n}, 8'h00);
        pulse(op_done);
        rd(16'h0100, v);
        chk("R3 array after resumed erase", v, 8'h22);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule